// File: doc/BRIEF.md
# Rotated-Recompute Self-Checking ALU

This block wraps a 32-bit adder/logic unit so that every operation is computed twice on the same hardware. The first pass uses the operands as they are. The second pass moves the operands by one 11-bit chunk before they reach the slot array. The operands are zero-extended to 33 bits so that they split into three equal chunks. A multiplexer on each slot's carry input takes the carry from whichever slot holds the next lower logical chunk. This keeps arithmetic correct in either placement. The second result is moved back into natural order and compared with the first. A stuck bit in a physical slot, or a broken carry path, then corrupts different logical bits in the two passes and shows up as a disagreement.

A caller presents an opcode and two operands with a valid/ready handshake. A result appears only when both passes agree. A disagreement gives a one-cycle mismatch pulse to a diagnosis controller instead, and the block stays blocked until that controller clears it. A stuck-at fault can be placed on any physical result bit through a mask and a stuck value, so that the detection path can be exercised.

Top module: `rotcheck_alu`

## Requirements
- R1: While reset is applied and in the first cycle after it, `in_ready` is 1 and `out_valid` and `out_mismatch` are 0.
- R2: Opcode 0 returns `a + b` modulo 2^32 and opcode 1 returns `a - b` modulo 2^32.
- R3: Opcode 2 returns bitwise AND, opcode 3 returns bitwise OR and opcode 4 returns bitwise XOR of the operands.
- R4: Opcodes 5, 6 and 7 return zero.
- R5: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. The outcome (`out_valid` or `out_mismatch`) is high for exactly one cycle, starting at the third rising edge after acceptance.
- R6: `in_ready` is 0 from the edge of acceptance until the outcome edge. Requests presented during that time are ignored and produce no result.
- R7: Carries and borrows that cross the 11-bit chunk boundaries (bits 10/11 and 21/22) and the top of the word give correct results and no mismatch in a fault-free block.
- R8: When the injected fault (`fault_mask` selects physical result bits, which are forced to `fault_val`) makes the two passes disagree, `out_mismatch` pulses for one cycle, `out_valid` stays 0 and `out_result` keeps its previous value. A fault that leaves both passes unchanged gives a normal result.
- R9: After a mismatch, `in_ready` stays 0 until `err_clear` is sampled high. In the cycle after that edge, `in_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 xor) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| err_clear | input | 1 | Releases the block after a mismatch |
| fault_mask | input | 33 | Physical result bits forced to the stuck value |
| fault_val | input | 1 | Stuck value applied to masked bits |
| out_valid | output | 1 | One-cycle strobe for an agreed result |
| out_result | output | 32 | Last agreed result |
| out_mismatch | output | 1 | One-cycle strobe: passes disagreed |

## Verification
The bench builds the block with its default parameters: 11-bit chunks, three chunks and a 32-bit word. With these values the carry steering is tested at the real boundaries, bits 10/11 and 21/22, and in the wrap from the top chunk into the lowest slot during the rotated pass. A stuck-at-1 on physical bit 0 moves to logical bit 22 in the rotated pass, which makes a mismatch happen for certain. A stuck-at-0 on the same bit with zero operands shows that a fault with no effect on either pass is not reported.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_XOR = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_SWAP,
        ST_CMP,
        ST_HALT
    } rc_state_e;

endpackage

// File: rtl/rc_chunk_rotate.sv
// Moves every chunk by one position, upward (UP=1) or downward (UP=0),
// when en is set; passes the bus through unchanged otherwise.
module rc_chunk_rotate #(
    parameter int CHUNK_W    = 11,
    parameter int NUM_CHUNKS = 3,
    parameter bit UP         = 1'b1,
    localparam int TOT_W     = CHUNK_W * NUM_CHUNKS
) (
    input  logic             en,
    input  logic [TOT_W-1:0] din,
    output logic [TOT_W-1:0] dout
);

    for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_chunk
        localparam int DST = UP ? ((k + 1) % NUM_CHUNKS)
                                : ((k + NUM_CHUNKS - 1) % NUM_CHUNKS);
        assign dout[DST*CHUNK_W +: CHUNK_W] = en ? din[k*CHUNK_W +: CHUNK_W]
                                                 : din[DST*CHUNK_W +: CHUNK_W];
    end

endmodule

// File: rtl/rc_slot_array.sv
// Physical slot array: operands are placed into slots (rotated or not),
// carries are steered in logical order, faults hit physical bits, and the
// result is returned to logical order.
module rc_slot_array #(
    parameter int CHUNK_W    = 11,
    parameter int NUM_CHUNKS = 3,
    localparam int TOT_W     = CHUNK_W * NUM_CHUNKS
) (
    input  logic             swap,
    input  logic [2:0]       op,
    input  logic [TOT_W-1:0] a_log,
    input  logic [TOT_W-1:0] b_log,
    input  logic [TOT_W-1:0] fault_mask,
    input  logic             fault_val,
    output logic [TOT_W-1:0] res_log
);
    import rc_pkg::*;

    logic [TOT_W-1:0] a_phys;
    logic [TOT_W-1:0] b_phys;
    logic [TOT_W-1:0] raw_phys;
    logic [TOT_W-1:0] hit_phys;

    rc_chunk_rotate #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS), .UP(1'b1)) u_rot_a (
        .en(swap), .din(a_log), .dout(a_phys)
    );
    rc_chunk_rotate #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS), .UP(1'b1)) u_rot_b (
        .en(swap), .din(b_log), .dout(b_phys)
    );

    // Walk the chunks in logical order; each step selects the physical slot
    // holding that chunk, so the carry mux feeds it from the lower chunk's slot.
    always_comb begin
        logic             carry;
        logic [CHUNK_W:0] sum;
        logic [CHUNK_W-1:0] ca;
        logic [CHUNK_W-1:0] cb;
        int               p;
        raw_phys = '0;
        carry    = (op == OP_SUB);
        for (int j = 0; j < NUM_CHUNKS; j++) begin
            p   = swap ? ((j + 1) % NUM_CHUNKS) : j;
            ca  = a_phys[p*CHUNK_W +: CHUNK_W];
            cb  = b_phys[p*CHUNK_W +: CHUNK_W];
            sum = {1'b0, ca} + {1'b0, (op == OP_SUB) ? ~cb : cb} + {{CHUNK_W{1'b0}}, carry};
            unique case (op)
                OP_ADD, OP_SUB: raw_phys[p*CHUNK_W +: CHUNK_W] = sum[CHUNK_W-1:0];
                OP_AND:         raw_phys[p*CHUNK_W +: CHUNK_W] = ca & cb;
                OP_OR:          raw_phys[p*CHUNK_W +: CHUNK_W] = ca | cb;
                OP_XOR:         raw_phys[p*CHUNK_W +: CHUNK_W] = ca ^ cb;
                default:        raw_phys[p*CHUNK_W +: CHUNK_W] = '0;
            endcase
            carry = sum[CHUNK_W];
        end
    end

    assign hit_phys = (raw_phys & ~fault_mask) | (fault_mask & {TOT_W{fault_val}});

    rc_chunk_rotate #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS), .UP(1'b0)) u_rot_back (
        .en(swap), .din(hit_phys), .dout(res_log)
    );

endmodule

// File: rtl/rotcheck_alu.sv
module rotcheck_alu #(
    parameter int CHUNK_W    = 11,
    parameter int NUM_CHUNKS = 3,
    parameter int DATA_W     = 32,
    localparam int TOT_W     = CHUNK_W * NUM_CHUNKS,
    localparam int PAD_W     = TOT_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              err_clear,
    input  logic [TOT_W-1:0]  fault_mask,
    input  logic              fault_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_mismatch
);
    import rc_pkg::*;

    typedef struct packed {
        rc_state_e         st;
        logic [2:0]        op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] res_n;
        logic [DATA_W-1:0] res_s;
        logic [DATA_W-1:0] result;
        logic              valid;
        logic              mismatch;
    } core_t;

    core_t            reg_d;
    core_t            reg_q;
    logic [TOT_W-1:0] dp_res;
    logic             dp_swap;

    assign dp_swap = (reg_q.st == ST_SWAP);

    rc_slot_array #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_slots (
        .swap      (dp_swap),
        .op        (reg_q.op),
        .a_log     ({{PAD_W{1'b0}}, reg_q.a}),
        .b_log     ({{PAD_W{1'b0}}, reg_q.b}),
        .fault_mask(fault_mask),
        .fault_val (fault_val),
        .res_log   (dp_res)
    );

    always_comb begin
        reg_d          = reg_q;
        reg_d.valid    = 1'b0;
        reg_d.mismatch = 1'b0;
        unique case (reg_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    reg_d.op = in_op;
                    reg_d.a  = in_a;
                    reg_d.b  = in_b;
                    reg_d.st = ST_NORM;
                end
            end
            ST_NORM: begin
                reg_d.res_n = dp_res[DATA_W-1:0];
                reg_d.st    = ST_SWAP;
            end
            ST_SWAP: begin
                reg_d.res_s = dp_res[DATA_W-1:0];
                reg_d.st    = ST_CMP;
            end
            ST_CMP: begin
                if (reg_q.res_n == reg_q.res_s) begin
                    reg_d.result = reg_q.res_n;
                    reg_d.valid  = 1'b1;
                    reg_d.st     = ST_IDLE;
                end else begin
                    reg_d.mismatch = 1'b1;
                    reg_d.st       = ST_HALT;
                end
            end
            ST_HALT: begin
                if (err_clear) reg_d.st = ST_IDLE;
            end
            default: reg_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q    <= '0;
            reg_q.st <= ST_IDLE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign in_ready     = (reg_q.st == ST_IDLE);
    assign out_valid    = reg_q.valid;
    assign out_result   = reg_q.result;
    assign out_mismatch = reg_q.mismatch;

    // R8: a released result and a mismatch never appear together
    a_r8_valid_xor_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_mismatch));

    // R5: outcome strobes last one cycle
    a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r5_mismatch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_mismatch |=> !out_mismatch);

    // R6: acceptance makes the block busy
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: out_result moves only together with out_valid
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result) || $past(!rst_n));

    // R9: after a mismatch the block stays blocked until cleared
    a_r9_halt_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mismatch && !err_clear) |=> !in_ready);

endmodule

// File: tb/rotcheck_alu_bench.sv
`timescale 1ns/1ps
module rotcheck_alu_bench;

    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        err_clear = 1'b0;
    logic [32:0] fault_mask = '0;
    logic        fault_val = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_mismatch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rotcheck_alu u_rotcheck_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .err_clear(err_clear),
        .fault_mask(fault_mask), .fault_val(fault_val), .out_valid(out_valid),
        .out_result(out_result), .out_mismatch(out_mismatch)
    );

    // rows: R2 add/sub, R7 boundary carries, R3 logic ops, R4 unused codes
    localparam logic [2:0]  V_OP  [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd1,
                                           3'd2, 3'd3, 3'd4, 3'd5, 3'd7, 3'd0};
    localparam logic [31:0] V_A   [NV] = '{32'h5, 32'h7FF, 32'h3FFFFF, 32'hFFFFFFFF,
                                           32'd10, 32'h0, 32'h00400000, 32'hF0F0F0F0,
                                           32'hF0F0F0F0, 32'hAAAA5555, 32'h12345678,
                                           32'hFFFFFFFF, 32'h12345678};
    localparam logic [31:0] V_B   [NV] = '{32'h3, 32'h1, 32'h1, 32'h1, 32'd3, 32'h1,
                                           32'h1, 32'hFF00FF00, 32'h0F0F0000,
                                           32'hFFFF0000, 32'h9, 32'hFFFFFFFF, 32'h87654321};
    localparam logic [31:0] V_EXP [NV] = '{32'h8, 32'h800, 32'h00400000, 32'h0,
                                           32'd7, 32'hFFFFFFFF, 32'h003FFFFF, 32'hF000F000,
                                           32'hFFFFF0F0, 32'h55555555, 32'h0, 32'h0,
                                           32'h99999999};
    localparam int          V_REQ [NV] = '{2, 7, 7, 7, 2, 7, 7, 3, 3, 3, 4, 4, 2};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // starts at a falling edge; returns at the falling edge after the outcome
    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_res, input bit exp_mm, input string req);
        bit early;
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R6", "ready low after accept", {31'd0, in_ready}, 32'd0);
        early = out_valid | out_mismatch;
        @(negedge clk);
        early = early | out_valid | out_mismatch;
        @(negedge clk);
        early = early | out_valid | out_mismatch;
        check(!early, "R5", "no early outcome", {31'd0, early}, 32'd0);
        @(negedge clk);
        check(out_valid == !exp_mm, req, "out_valid", {31'd0, out_valid}, {31'd0, !exp_mm});
        check(out_mismatch == exp_mm, req, "out_mismatch", {31'd0, out_mismatch}, {31'd0, exp_mm});
        check(out_result == exp_res, req, "out_result", out_result, exp_res);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready && !out_valid && !out_mismatch, "R1", "during reset",
              {29'd0, in_ready, out_valid, out_mismatch}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid && !out_mismatch, "R1", "after reset",
              {29'd0, in_ready, out_valid, out_mismatch}, 32'd4);

        for (int i = 0; i < NV; i++) begin
            do_op(V_OP[i], V_A[i], V_B[i], V_EXP[i], 1'b0, $sformatf("R%0d", V_REQ[i]));
            @(negedge clk);
            check(!out_valid, "R5", "valid one cycle", {31'd0, out_valid}, 32'd0);
        end

        // R6: requests presented while busy are ignored
        in_valid = 1'b1; in_op = 3'd0; in_a = 32'd1; in_b = 32'd1;
        @(posedge clk);
        @(negedge clk);
        in_a = 32'd100; in_b = 32'd100;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid && out_result == 32'd2, "R6", "busy request ignored", out_result, 32'd2);
        @(negedge clk);
        check(!out_valid && in_ready, "R6", "no second result",
              {30'd0, out_valid, in_ready}, 32'd1);

        // R8: stuck-at-0 on bit 0 with zero operands alters neither pass
        fault_mask = 33'd1; fault_val = 1'b0;
        do_op(3'd0, 32'd0, 32'd0, 32'd0, 1'b0, "R8");
        @(negedge clk);

        // R8: stuck-at-1 on physical bit 0 lands on logical bit 22 when rotated
        fault_val = 1'b1;
        do_op(3'd0, 32'd0, 32'd0, 32'd0, 1'b1, "R8");
        @(negedge clk);
        check(!out_mismatch, "R8", "mismatch one cycle", {31'd0, out_mismatch}, 32'd0);

        // R9: blocked until cleared
        in_valid = 1'b1; in_op = 3'd0; in_a = 32'd5; in_b = 32'd5;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!in_ready && !out_valid, "R9", "held after mismatch",
                  {30'd0, in_ready, out_valid}, 32'd0);
        end
        in_valid = 1'b0;
        fault_mask = '0;
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check(in_ready, "R9", "ready after clear", {31'd0, in_ready}, 32'd1);
        do_op(3'd0, 32'd5, 32'd5, 32'd10, 1'b0, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule